// File: doc/BRIEF.md
# Byte/Word Shift and Rotate Unit with Flag Outputs

This unit takes a byte or word operand and applies one of five movements to it: rotate left, rotate right, rotate right through the carry, shift left with zero fill, and arithmetic shift right with sign fill. The count is either a fixed one or an 8-bit value taken from a count register. The unit also takes the incoming carry flag. It returns the moved operand together with carry, overflow, sign, zero and parity flags, and a mask that marks which of those flags the operation defines.

A core's execute stage drives the unit once per cycle. The result and flags come out of a register one clock later. The caller merges each flag whose mask bit is set into its own status word and keeps the old value of every other flag. A count of zero, or an operation code the unit does not assign, produces an empty mask, so the caller's flags stay as they were.

Top module: `shift_rotate_flags`

## Requirements
- R1: Operation code 0 rotates left: the bit leaving the top position enters bit 0. Carry (flag bit 0) equals the bit that left the top position last.
- R2: Operation code 1 rotates right: the bit leaving bit 0 enters the top position. Carry equals the bit that left bit 0 last.
- R3: Operation code 2 rotates right through the carry: bit 0 moves into carry and the old carry moves into the top position. For example, a byte rotated by 4 ends with carry equal to the original bit 3 and bit 4 equal to the incoming carry.
- R4: Operation code 3 shifts left and fills bit 0 with zero. Carry is the last bit shifted out of the top position. A count equal to the width leaves carry equal to the original bit 0. A count greater than the width gives a zero result with carry 0.
- R5: Operation code 4 shifts right and copies the original sign bit into the top position. Carry is the last bit shifted out of bit 0. A count of the width or more gives all sign bits, with carry equal to the sign.
- R6: When the count is one, overflow (flag bit 1) is defined. For the three rotates it is 1 when the top bit of the result differs from the top bit of the operand. For the left shift it is carry XOR the top result bit. For counts above one, the rotates and the left shift clear the overflow mask bit.
- R7: For the arithmetic right shift, overflow is always defined. With a count of one it is 1 when the two top bits of the operand differ. With any larger count it is 0.
- R8: The two shifts set sign (bit 2) from the top result bit and zero (bit 3) from an all-zero result. Parity (bit 4) is 1 when the low 8 result bits hold an even number of ones, and its mask bit is set only in byte mode. The rotates set only the carry and overflow mask bits.
- R9: A count of zero returns the operand unchanged (byte mode clears the upper half) with an all-zero mask.
- R10: When `use_cl_i` is 0 the count is one and `cl_i` has no effect. Otherwise `cl_i` is used as given, up to 255. Rotates through carry repeat every width+1 steps; the other rotates repeat every width steps.
- R11: When `wide_i` is 0 the unit works on the low 8 bits only. The upper result bits are 0 and the top bit is bit 7.
- R12: Operation codes 5 to 7 return the operand unchanged with an all-zero mask.
- R13: Outputs are registered with one cycle of latency and are 0 during reset. A flag output whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 ROL, 1 ROR, 2 RCR, 3 SHL, 4 SAR) |
| wide_i | input | 1 | 1 selects word width, 0 selects byte width |
| opnd_i | input | W | Operand |
| use_cl_i | input | 1 | 1 takes the count from cl_i, 0 uses a count of one |
| cl_i | input | 8 | Count register value |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | W | Result |
| flags_o | output | 5 | {PF, ZF, SF, OF, CF} |
| fmask_o | output | 5 | Defined/updated mask, same bit order as flags_o |

## Verification
Two functions can land in the same cycle: the count wrapping around for a rotate, and the count being exactly zero. A rotate-through-carry byte with count 9, or a plain word rotate with count 16, returns the operand bits unchanged, just as a zero count does. Unlike a zero count, it still sets the carry mask, and carry takes the value the wrap leaves. The bench drives these wrap counts right next to true zero counts. It judges both against a step-by-step reference that really moves the bits once per count unit, so a design that treats a wrapped count as zero loses the carry mask and is reported.

// File: rtl/shift_rotate_flags.sv
module shift_rotate_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic         wide_i,
  input  logic [W-1:0] opnd_i,
  input  logic         use_cl_i,
  input  logic [7:0]   cl_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic [4:0]   flags_o,
  output logic [4:0]   fmask_o
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] LOW = {{(W-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [2:0] OP_ROL = 3'd0, OP_ROR = 3'd1, OP_RCR = 3'd2,
                         OP_SHL = 3'd3, OP_SAR = 3'd4;

  int           w, n, r;
  logic [W-1:0] src, nxt;
  logic [W:0]   ext, rot;
  logic         cf, of;
  logic [4:0]   m, fl;

  always_comb begin
    w   = wide_i ? W : HALF;
    n   = use_cl_i ? 32'(cl_i) : 1;
    src = wide_i ? opnd_i : (opnd_i & LOW);
    nxt = src;
    cf  = 1'b0;
    of  = 1'b0;
    m   = '0;
    r   = 0;
    ext = '0;
    rot = '0;
    if (n != 0 && op_i <= OP_SAR) begin
      m[0] = 1'b1;
      nxt  = '0;
      case (op_i)
        OP_ROL: begin
          r = n % w;
          for (int i = 0; i < W; i++)
            if (i < w) nxt[i] = opnd_i[(i - r + w) % w];
          cf = nxt[0];
        end
        OP_ROR: begin
          r = n % w;
          for (int i = 0; i < W; i++)
            if (i < w) nxt[i] = opnd_i[(i + r) % w];
          cf = nxt[w-1];
        end
        OP_RCR: begin
          r = n % (w + 1);
          for (int i = 0; i < W; i++)
            if (i < w) ext[i] = opnd_i[i];
          ext[w] = carry_i;
          for (int i = 0; i <= W; i++)
            if (i <= w) rot[i] = ext[(i + r) % (w + 1)];
          for (int i = 0; i < W; i++)
            if (i < w) nxt[i] = rot[i];
          cf = rot[w];
        end
        OP_SHL: begin
          for (int i = 0; i < W; i++)
            if (i < w && i >= n) nxt[i] = opnd_i[i - n];
          cf = (n <= w) ? opnd_i[w - n] : 1'b0;
        end
        default: begin
          for (int i = 0; i < W; i++)
            if (i < w) nxt[i] = (i + n < w) ? opnd_i[i + n] : opnd_i[w-1];
          cf = (n <= w) ? opnd_i[n - 1] : opnd_i[w-1];
        end
      endcase
      if (op_i == OP_SAR) begin
        m[1] = 1'b1;
        of   = (n == 1) ? (opnd_i[w-1] ^ opnd_i[w-2]) : 1'b0;
      end else if (n == 1) begin
        m[1] = 1'b1;
        of   = (op_i == OP_SHL) ? (cf ^ nxt[w-1]) : (nxt[w-1] ^ opnd_i[w-1]);
      end
      if (op_i >= OP_SHL) begin
        m[2] = 1'b1;
        m[3] = 1'b1;
        m[4] = ~wide_i;
      end
    end
  end

  assign fl = {~^nxt[7:0], nxt == '0, nxt[w-1], of, cf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      flags_o <= '0;
      fmask_o <= '0;
    end else begin
      res_o   <= nxt;
      flags_o <= fl & m;
      fmask_o <= m;
    end
  end
endmodule

// File: rtl/shift_rotate_flags_chk.sv
module shift_rotate_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_i,
  input logic         wide_i,
  input logic [W-1:0] opnd_i,
  input logic         use_cl_i,
  input logic [7:0]   cl_i,
  input logic         carry_i,
  input logic [W-1:0] res_o,
  input logic [4:0]   flags_o,
  input logic [4:0]   fmask_o
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] LOW = {{(W-HALF){1'b0}}, {HALF{1'b1}}};

  AST_UNMASKED_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~fmask_o) == 5'd0); // R13

  AST_ZERO_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (use_cl_i && cl_i == 8'd0) |=> (fmask_o == 5'd0 &&
      res_o == ($past(wide_i) ? $past(opnd_i) : ($past(opnd_i) & LOW)))); // R9

  AST_ROTATE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 3'd2 && !(use_cl_i && cl_i == 8'd0)) |=> (fmask_o[0] && fmask_o[4:2] == 3'd0)); // R8

  AST_MULTI_OF_UNDEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 3'd3 && use_cl_i && cl_i > 8'd1) |=> !fmask_o[1]); // R6

  AST_SAR_MULTI_OF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 && use_cl_i && cl_i > 8'd1) |=> (fmask_o[1] && !flags_o[1])); // R7

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> res_o[W-1:HALF] == '0); // R11

  AST_SPARE_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    op_i > 3'd4 |=> fmask_o == 5'd0); // R12

  AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && !use_cl_i) |=> !res_o[0]); // R4
endmodule

bind shift_rotate_flags shift_rotate_flags_chk #(.W(W)) u_chk (.*);

// File: tb/sim_shift_rotate_flags.sv
`timescale 1ns/1ps
module sim_shift_rotate_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [15:0] opnd_i = '0;
  logic        use_cl_i = 1'b0;
  logic [7:0]  cl_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] res_o;
  logic [4:0]  flags_o, fmask_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int    q_res[$];
  int    q_flg[$];
  int    q_msk[$];
  string q_tag[$];

  always #5 clk = ~clk;

  shift_rotate_flags #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i), .opnd_i(opnd_i),
    .use_cl_i(use_cl_i), .cl_i(cl_i), .carry_i(carry_i),
    .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o));

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  task automatic model(input int op, input int wide, input int opnd, input int ucl,
                       input int cl, input int cin, output int r, output int f, output int m);
    int w, n, wm, x, c, nc, sg, of, pf, zf, sf;
    w  = wide ? 16 : 8;
    wm = (1 << w) - 1;
    n  = ucl ? cl : 1;
    x  = opnd & wm;
    c  = cin;
    if (op > 4 || n == 0) begin
      r = x; f = 0; m = 0;
      return;
    end
    for (int k = 0; k < n; k++) begin
      case (op)
        0: begin c = bitof(x, w-1); x = ((x << 1) | c) & wm; end
        1: begin c = bitof(x, 0); x = (x >> 1) | (c << (w-1)); end
        2: begin nc = bitof(x, 0); x = (x >> 1) | (c << (w-1)); c = nc; end
        3: begin c = bitof(x, w-1); x = (x << 1) & wm; end
        default: begin c = bitof(x, 0); sg = bitof(x, w-1); x = (x >> 1) | (sg << (w-1)); end
      endcase
    end
    r = x;
    m = 1;
    of = 0;
    if (op == 4) begin
      m |= 2;
      if (n == 1) of = bitof(opnd, w-1) ^ bitof(opnd, w-2);
    end else if (n == 1) begin
      m |= 2;
      if (op == 3) of = c ^ bitof(x, w-1);
      else         of = bitof(x, w-1) ^ bitof(opnd, w-1);
    end
    sf = bitof(x, w-1);
    zf = (x == 0) ? 1 : 0;
    pf = 1;
    for (int k = 0; k < 8; k++) pf ^= bitof(x, k);
    if (op >= 3) begin
      m |= 4 | 8;
      if (!wide) m |= 16;
    end
    f = (c | (of << 1) | (sf << 2) | (zf << 3) | (pf << 4)) & m;
  endtask

  task automatic apply(input int op, input int wide, input int opnd, input int ucl,
                       input int cl, input int cin, input string tag);
    int r, f, m;
    @(negedge clk);
    op_i = 3'(op); wide_i = 1'(wide); opnd_i = 16'(opnd);
    use_cl_i = 1'(ucl); cl_i = 8'(cl); carry_i = 1'(cin);
    model(op, wide, opnd, ucl, cl, cin, r, f, m);
    q_res.push_back(r); q_flg.push_back(f); q_msk.push_back(m); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q_res.size() > 0) begin
      int er, ef, em;
      string t;
      er = q_res.pop_front(); ef = q_flg.pop_front();
      em = q_msk.pop_front(); t = q_tag.pop_front();
      checks++;
      if (int'(res_o) != er || int'(flags_o) != ef || int'(fmask_o) != em) begin
        errors++;
        $display("FAIL %s: got res=%h flags=%b mask=%b, expected res=%h flags=%b mask=%b",
                 t, res_o, flags_o, fmask_o, 16'(er), 5'(ef), 5'(em));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_o != 16'h0 || flags_o != 5'h0 || fmask_o != 5'h0) begin
      errors++;
      $display("FAIL R13: got res=%h flags=%b mask=%b, expected all zero", res_o, flags_o, fmask_o);
    end
    rst_n = 1'b1;

    apply(0, 1, 'h8001, 0, 0, 0, "R1");
    apply(0, 1, 'h1234, 1, 3, 1, "R1");
    apply(1, 1, 'h0001, 0, 0, 0, "R2");
    apply(1, 0, 'h00A5, 1, 5, 0, "R2");
    apply(2, 0, 'h005A, 1, 4, 1, "R3");
    apply(2, 1, 'h0001, 0, 0, 0, "R3");
    apply(3, 1, 'h4001, 1, 16, 0, "R4");
    apply(3, 1, 'hFFFF, 1, 17, 1, "R4");
    apply(4, 1, 'h8010, 1, 20, 0, "R5");
    apply(4, 0, 'h0081, 1, 3, 0, "R5");
    apply(1, 0, 'h0001, 0, 0, 0, "R6");
    apply(3, 1, 'h4000, 0, 0, 0, "R6");
    apply(0, 1, 'h4000, 1, 2, 0, "R6");
    apply(4, 1, 'h4000, 0, 0, 0, "R7");
    apply(4, 1, 'hC000, 1, 3, 0, "R7");
    apply(3, 0, 'h0080, 0, 0, 0, "R8");
    apply(3, 1, 'h0303, 1, 1, 0, "R8");
    apply(2, 1, 'h0000, 1, 1, 1, "R8");
    apply(0, 1, 'hBEEF, 1, 0, 1, "R9");
    apply(2, 0, 'hFF3C, 1, 0, 1, "R9");
    apply(1, 1, 'h0F0F, 0, 'h55, 0, "R10");
    apply(2, 0, 'h0096, 1, 9, 1, "R10");
    apply(2, 1, 'h8421, 1, 17, 0, "R10");
    apply(0, 0, 'h00C3, 1, 8, 0, "R10");
    apply(1, 1, 'h9C31, 1, 255, 0, "R10");
    apply(4, 0, 'hAB7F, 1, 1, 0, "R11");
    apply(0, 0, 'hFF80, 0, 0, 1, "R11");
    apply(6, 1, 'h1357, 1, 2, 1, "R12");
    apply(5, 0, 'h2468, 0, 0, 0, "R12");

    for (int i = 0; i < 3000; i++) begin
      int op, cl;
      op = $urandom_range(0, 7);
      cl = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 18);
      apply(op, $urandom_range(0, 1), $urandom_range(0, 65535), $urandom_range(0, 1),
            cl, $urandom_range(0, 1), (op > 4) ? "R12" : $sformatf("R%0d", op + 1));
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule